// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt source lines from five banks of 32 lines each. A rising edge on a source line sets a sticky pending bit. Software clears a pending bit by writing a one to the matching position of that bank's clear register. A fixed table assigns some lines a priority level from 1 to 15; every other line has level 0.

Lines with a nonzero level bypass the bank enables. They feed a high-level interrupt output, gated per level by a priority mask, and the status word reports the highest pending, enabled level as a 4-bit vector. All remaining lines are gated by their bank enable bits and OR-reduced onto a separate low-level output. One global enable bit gates both outputs. Both outputs are registered.

Registers are reached through a simple port with a write strobe and a separate combinational read address.

Top module: `irq_twolevel_ctrl`

## Requirements
- R1: A rising edge on a source line, after a two-flop synchronizer, sets the matching pending bit. The bit stays set while the line stays high after it is cleared; only a new rising edge sets it again. Pending bits read at address 0..4 for bank index 0..4.
- R2: Writing a pattern to the clear register of bank index b (address 16+b) clears exactly the pending bits written as 1 and leaves the others. Writing back the full status clears the whole bank.
- R3: When a rising edge and a clear of the same bit land in the same cycle, the bit stays set.
- R4: A line with level 0 drives the low output only when its bank enable bit is set. Enables are at address 8+b, read and write.
- R5: A line with a nonzero level never drives the low output, even when its bank enable bit is set.
- R6: The level table, by bank index and bit: index 4 bits 25 and 24 are level 15, index 4 bit 30 is level 14, index 4 bit 29 is level 13, index 0 bit 18 is level 4, index 0 bit 17 is level 3, index 0 bit 27 is level 2, and index 4 bits 7 and 0 are level 1. A pending table line drives the high output only when control bit L of its level L is set.
- R7: The status word (address 25, read only) holds the high-pending flag in bit 31, the low-pending flag in bit 30, and in bits 3:0 the highest level with a pending line whose control bit is set, or 0 when there is none. Higher levels win.
- R8: Control register (address 24) bit 0 is the global enable. When it is clear, both outputs stay low, while the pending bits and the status word still read normally.
- R9: Both outputs are registered and change one clock cycle after the pending, enable or control state that drives them changes.
- R10: Reset clears all pending, enable and control bits, and both outputs read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 160 | Source lines; bank index b, bit i at position b*32+i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_hi_o | output | 1 | Prioritized high-level interrupt |
| irq_lo_o | output | 1 | Masked-OR low-level interrupt |

## Verification
Single plain lines, enabled and not enabled, show that the low path honours the bank enables. A table line with its bank enable set shows that the low path ignores it. Mixes of several levels pending at once, with masks switched on and off, tell a correct highest-level pick apart from a lowest-level or unmasked one. The source held high across a clear separates edge capture from level capture. An edge that lands in the same cycle as its clear shows which of the two wins. Toggling the global enable, sampled on the exact cycle, exposes both missing gating and a missing output register.

// File: rtl/irq2l_pkg.sv
package irq2l_pkg;

  typedef enum logic [1:0] {
    K_STAT = 2'd0,
    K_EN   = 2'd1,
    K_CLR  = 2'd2,
    K_SYS  = 2'd3
  } reg_kind_e;

  localparam int SYS_CTRL = 0;
  localparam int SYS_SUM  = 1;

  // Fixed priority level of a source line; 0 means the line takes the low path.
  function automatic int line_level(input int bank, input int bitpos);
    int lvl;
    lvl = 0;
    if (bank == 4) begin
      case (bitpos)
        25, 24: lvl = 15;
        30:     lvl = 14;
        29:     lvl = 13;
        7, 0:   lvl = 1;
        default: lvl = 0;
      endcase
    end else if (bank == 0) begin
      case (bitpos)
        18:     lvl = 4;
        17:     lvl = 3;
        27:     lvl = 2;
        default: lvl = 0;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] src_i,
  input  logic [BW-1:0] clr_i,
  output logic [BW-1:0] rise_o,
  output logic [BW-1:0] status_o
);
  logic [BW-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      status_o <= '0;
    end else begin
      sync1_q  <= src_i;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
      // a fresh edge outranks a clear of the same bit
      status_o <= (status_o & ~clr_i) | rise_o;
    end
  end

  assign rise_o = sync2_q & ~prev_q;
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq2l_pkg::*;
#(
  parameter int NBANK = 5,
  parameter int BW    = 32,
  parameter int NLVL  = 15,
  parameter int VW    = 4
) (
  input  logic [NBANK*BW-1:0] status_i,
  input  logic [NLVL:1]       lvl_en_i,
  output logic [VW-1:0]       vec_o,
  output logic                hi_pend_o
);
  logic [NLVL:1] lvl_raw;
  logic [NLVL:1] lvl_act;

  always_comb begin
    lvl_raw = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int i = 0; i < BW; i++) begin
        if (line_level(b, i) >= 1 && line_level(b, i) <= NLVL)
          lvl_raw[line_level(b, i)] = lvl_raw[line_level(b, i)] | status_i[b*BW+i];
      end
    end
  end

  assign lvl_act   = lvl_raw & lvl_en_i;
  assign hi_pend_o = |lvl_act;

  always_comb begin
    vec_o = '0;
    for (int p = 1; p <= NLVL; p++) begin
      if (lvl_act[p]) vec_o = p[VW-1:0];
    end
  end
endmodule

// File: rtl/irq_low_gate.sv
module irq_low_gate
  import irq2l_pkg::*;
#(
  parameter int NBANK = 5,
  parameter int BW    = 32
) (
  input  logic [NBANK*BW-1:0] status_i,
  input  logic [NBANK*BW-1:0] enable_i,
  output logic                lo_pend_o
);
  logic [NBANK*BW-1:0] hi_map;

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    for (genvar gi = 0; gi < BW; gi++) begin : g_bit
      assign hi_map[gb*BW+gi] = (line_level(gb, gi) != 0);
    end
  end

  assign lo_pend_o = |(status_i & enable_i & ~hi_map);
endmodule

// File: rtl/irq_twolevel_ctrl.sv
module irq_twolevel_ctrl
  import irq2l_pkg::*;
#(
  parameter int NBANK = 5,
  parameter int BW    = 32,
  parameter int NLVL  = 15,
  parameter int AW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*BW-1:0] src_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [BW-1:0]       wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [BW-1:0]       rd_data_o,
  output logic                irq_hi_o,
  output logic                irq_lo_o
);
  localparam int VW = $clog2(NLVL + 1);
  localparam int IW = AW - 2;

  // named internal events, also used by the bound checker
  logic [NBANK*BW-1:0] status_flat;
  logic [NBANK*BW-1:0] rise_flat;
  logic [NBANK*BW-1:0] clr_flat;
  logic [NBANK*BW-1:0] en_q;
  logic                glob_en_q;
  logic [NLVL:1]       lvl_en_q;
  logic                hi_pend, lo_pend;
  logic [VW-1:0]       vec;

  reg_kind_e       wr_kind, rd_kind;
  logic [IW-1:0]   wr_idx, rd_idx;

  assign wr_kind = reg_kind_e'(wr_addr_i[AW-1:AW-2]);
  assign wr_idx  = wr_addr_i[IW-1:0];
  assign rd_kind = reg_kind_e'(rd_addr_i[AW-1:AW-2]);
  assign rd_idx  = rd_addr_i[IW-1:0];

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    assign clr_flat[gb*BW +: BW] =
      (wr_en_i && wr_kind == K_CLR && int'(wr_idx) == gb) ? wr_data_i : '0;

    irq_edge_bank #(.BW(BW)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[gb*BW +: BW]),
      .clr_i    (clr_flat[gb*BW +: BW]),
      .rise_o   (rise_flat[gb*BW +: BW]),
      .status_o (status_flat[gb*BW +: BW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      glob_en_q <= 1'b0;
      lvl_en_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_kind == K_EN && int'(wr_idx) < NBANK)
        en_q[int'(wr_idx)*BW +: BW] <= wr_data_i;
      if (wr_kind == K_SYS && int'(wr_idx) == SYS_CTRL) begin
        glob_en_q <= wr_data_i[0];
        lvl_en_q  <= wr_data_i[NLVL:1];
      end
    end
  end

  irq_prio_encoder #(.NBANK(NBANK), .BW(BW), .NLVL(NLVL), .VW(VW)) enc_i (
    .status_i  (status_flat),
    .lvl_en_i  (lvl_en_q),
    .vec_o     (vec),
    .hi_pend_o (hi_pend)
  );

  irq_low_gate #(.NBANK(NBANK), .BW(BW)) low_i (
    .status_i  (status_flat),
    .enable_i  (en_q),
    .lo_pend_o (lo_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_hi_o <= 1'b0;
      irq_lo_o <= 1'b0;
    end else begin
      irq_hi_o <= glob_en_q & hi_pend;
      irq_lo_o <= glob_en_q & lo_pend;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_kind)
      K_STAT: if (int'(rd_idx) < NBANK) rd_data_o = status_flat[int'(rd_idx)*BW +: BW];
      K_EN:   if (int'(rd_idx) < NBANK) rd_data_o = en_q[int'(rd_idx)*BW +: BW];
      K_SYS: begin
        if (int'(rd_idx) == SYS_CTRL) rd_data_o[NLVL:0] = {lvl_en_q, glob_en_q};
        if (int'(rd_idx) == SYS_SUM) begin
          rd_data_o[BW-1]   = hi_pend;
          rd_data_o[BW-2]   = lo_pend;
          rd_data_o[VW-1:0] = vec;
        end
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

module irq_twolevel_chk #(
  parameter int NB = 160,
  parameter int VW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glob_en,
  input logic          hi_pend,
  input logic          lo_pend,
  input logic [VW-1:0] vec,
  input logic          irq_hi,
  input logic          irq_lo,
  input logic [NB-1:0] status_flat,
  input logic [NB-1:0] rise_flat,
  input logic [NB-1:0] clr_flat
);
  // R1
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_flat) & ~status_flat) == '0));
  // R2
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_flat) & ~$past(rise_flat)) & status_flat) == '0));
  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_flat) & ~$past(clr_flat)) & ~status_flat) == '0));
  // R8
  hi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> $past(glob_en));
  // R8
  lo_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> $past(glob_en));
  // R9
  hi_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_hi == $past(glob_en & hi_pend)));
  // R9
  lo_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_lo == $past(glob_en & lo_pend)));
  // R7
  hi_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ($past(vec) != '0));
endmodule

bind irq_twolevel_ctrl irq_twolevel_chk #(.NB(NBANK*BW), .VW(VW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .glob_en     (glob_en_q),
  .hi_pend     (hi_pend),
  .lo_pend     (lo_pend),
  .vec         (vec),
  .irq_hi      (irq_hi_o),
  .irq_lo      (irq_lo_o),
  .status_flat (status_flat),
  .rise_flat   (rise_flat),
  .clr_flat    (clr_flat)
);

// File: tb/irq_twolevel_ctrl_tb.sv
`timescale 1ns/10ps
module irq_twolevel_ctrl_tb_top;
  localparam int NBANK = 5;
  localparam int BW    = 32;
  localparam int AW    = 5;

  localparam int KIND_REG = 0;
  localparam int KIND_HI  = 1;
  localparam int KIND_LO  = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NBANK*BW-1:0] src = '0;
  logic                wr_en = 1'b0;
  logic [AW-1:0]       wr_addr = '0;
  logic [BW-1:0]       wr_data = '0;
  logic [AW-1:0]       rd_addr = '0;
  logic [BW-1:0]       rd_data;
  logic                irq_hi, irq_lo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int          kind;
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  irq_twolevel_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_hi_o  (irq_hi),
    .irq_lo_o  (irq_lo)
  );

  function automatic logic [4:0] a_stat(int b); return 5'(b);      endfunction
  function automatic logic [4:0] a_en(int b);   return 5'(8 + b);  endfunction
  function automatic logic [4:0] a_clr(int b);  return 5'(16 + b); endfunction
  localparam logic [4:0] A_CTRL = 5'd24;
  localparam logic [4:0] A_SUM  = 5'd25;

  // status word built by the bench from flags and level
  function automatic logic [31:0] sum_word(bit hi, bit lo, int lvl);
    logic [31:0] w;
    w = 32'(lvl);
    w[31] = hi;
    w[30] = lo;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_word(bit g, int l0, int l1, int l2);
    logic [31:0] w;
    w = '0;
    w[0] = g;
    if (l0 > 0) w[l0] = 1'b1;
    if (l1 > 0) w[l1] = 1'b1;
    if (l2 > 0) w[l2] = 1'b1;
    return w;
  endfunction

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: drains expected items at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        rd_addr = it.addr;
        #0.1;
        case (it.kind)
          KIND_REG: compare(it.tag, rd_data, it.exp);
          KIND_HI:  compare(it.tag, {31'b0, irq_hi}, it.exp);
          default:  compare(it.tag, {31'b0, irq_lo}, it.exp);
        endcase
      end
    end
  end

  task automatic exp_reg(logic [4:0] a, logic [31:0] e, string tag);
    sb_item_t it;
    it.kind = KIND_REG; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_out(bit hi, bit lo, string tag);
    sb_item_t it;
    it.addr = 5'd0; it.tag = tag;
    it.kind = KIND_HI; it.exp = 32'(hi); sb_q.push_back(it);
    it.kind = KIND_LO; it.exp = 32'(lo); sb_q.push_back(it);
  endtask

  task automatic flush();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(int b, int i);
    @(negedge clk);
    src[b*BW+i] = 1'b1;
    repeat (3) @(negedge clk);
    src[b*BW+i] = 1'b0;
    settle(4);
  endtask

  task automatic clear_all();
    for (int b = 0; b < NBANK; b++) wr(a_clr(b), 32'hFFFF_FFFF);
    settle(2);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R10 reset state
    for (int b = 0; b < NBANK; b++) exp_reg(a_stat(b), 32'h0, "R10 status after reset");
    exp_reg(a_en(2), 32'h0, "R10 enable after reset");
    exp_reg(A_CTRL, 32'h0, "R10 control after reset");
    exp_reg(A_SUM, 32'h0, "R10 summary after reset");
    exp_out(1'b0, 1'b0, "R10 outputs after reset");
    flush();

    // R1 R4 plain enabled line
    wr(A_CTRL, ctrl_word(1'b1, 0, 0, 0));
    wr(a_en(2), 32'h0000_0008);
    exp_reg(a_en(2), 32'h0000_0008, "R4 enable readback");
    pulse(2, 3);
    exp_reg(a_stat(2), 32'h0000_0008, "R1 edge latched");
    exp_reg(A_SUM, sum_word(1'b0, 1'b1, 0), "R7 low flag");
    exp_out(1'b0, 1'b1, "R4 low output on enabled line");
    flush();

    // R1 R2 level held high across a clear is not relatched
    @(negedge clk); src[2*BW+3] = 1'b1;
    settle(5);
    wr(a_clr(2), 32'h0000_0008);
    settle(4);
    exp_reg(a_stat(2), 32'h0, "R1 held level not relatched");
    exp_out(1'b0, 1'b0, "R2 low output drops after clear");
    flush();
    @(negedge clk); src[2*BW+3] = 1'b0;
    settle(4);

    // R4 line without enable
    pulse(2, 5);
    exp_reg(a_stat(2), 32'h0000_0020, "R4 unenabled line latched");
    exp_out(1'b0, 1'b0, "R4 unenabled line keeps low output off");
    flush();
    clear_all();

    // R2 partial clear
    pulse(1, 0);
    pulse(1, 31);
    pulse(3, 9);
    wr(a_clr(1), 32'h0000_0001);
    settle(1);
    exp_reg(a_stat(1), 32'h8000_0000, "R2 partial clear");
    exp_reg(a_stat(3), 32'h0000_0200, "R2 other bank untouched");
    flush();
    wr(a_clr(1), 32'h8000_0000);
    wr(a_clr(3), 32'h0000_0200);
    settle(1);
    exp_reg(a_stat(1), 32'h0, "R2 write-back clears bank");
    exp_reg(a_stat(3), 32'h0, "R2 write-back clears bank 3");
    flush();

    // R5 R6 table line with bank enable set, mask off
    wr(a_en(0), 32'h0004_0000);
    pulse(0, 18);
    exp_reg(a_stat(0), 32'h0004_0000, "R5 table line latched");
    exp_reg(A_SUM, sum_word(1'b0, 1'b0, 0), "R6 masked level gives vector 0");
    exp_out(1'b0, 1'b0, "R5 table line not on low output");
    flush();
    wr(A_CTRL, ctrl_word(1'b1, 4, 1, 14));
    settle(1);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 4), "R6 level 4 enabled");
    exp_out(1'b1, 1'b0, "R6 high output on enabled level");
    flush();

    // R7 several levels pending
    pulse(4, 7);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 4), "R7 level 4 beats level 1");
    flush();
    pulse(4, 30);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 14), "R7 level 14 wins");
    flush();
    pulse(4, 29);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 14), "R6 level 13 masked has no effect");
    flush();
    wr(A_CTRL, ctrl_word(1'b1, 1, 13, 0));
    settle(1);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 13), "R6 mask swap picks 13");
    flush();
    wr(a_clr(4), 32'h2000_0000);
    settle(1);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 1), "R7 falls back to level 1");
    flush();
    pulse(4, 25);
    wr(A_CTRL, ctrl_word(1'b1, 1, 15, 0));
    settle(1);
    exp_reg(A_SUM, sum_word(1'b1, 1'b0, 15), "R6 power-good level 15");
    flush();
    clear_all();
    wr(A_CTRL, ctrl_word(1'b1, 4, 1, 14));
    settle(1);
    exp_reg(A_SUM, 32'h0, "R7 vector 0 when nothing pending");
    exp_out(1'b0, 1'b0, "R7 outputs idle when nothing pending");
    flush();

    // R8 R9 global enable gating and exact timing
    pulse(2, 3);
    pulse(0, 18);
    exp_out(1'b1, 1'b1, "R8 both outputs on with global enable");
    flush();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CTRL; wr_data = ctrl_word(1'b0, 4, 1, 14);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    #0.1;
    compare("R9 high output still on one cycle before", {31'b0, irq_hi}, 32'h1);
    compare("R9 low output still on one cycle before", {31'b0, irq_lo}, 32'h1);
    @(negedge clk);
    #0.1;
    compare("R9 R8 high output off after global disable", {31'b0, irq_hi}, 32'h0);
    compare("R9 R8 low output off after global disable", {31'b0, irq_lo}, 32'h0);
    exp_reg(A_SUM, sum_word(1'b1, 1'b1, 4), "R8 status word readable while disabled");
    exp_reg(a_stat(2), 32'h0000_0008, "R8 pending kept while disabled");
    flush();
    wr(A_CTRL, ctrl_word(1'b1, 4, 1, 14));
    settle(1);
    exp_out(1'b1, 1'b1, "R8 outputs return with global enable");
    flush();
    clear_all();

    // R3 edge and clear in the same cycle
    @(negedge clk); src[3*BW+4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a_clr(3); wr_data = 32'h0000_0010;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    src[3*BW+4] = 1'b0;
    settle(2);
    exp_reg(a_stat(3), 32'h0000_0010, "R3 edge wins over same-cycle clear");
    flush();

    settle(2);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule